// File: doc/BRIEF.md
# Multichannel Conversion Sequencer with Ready Flags

This block drives repeated conversions over a set of enabled channels inside a converter's digital core. A host issues a mode write that chooses a starting channel and either requests continuous conversion or stops the sequencer. While running, the block times each conversion with the count programmed for that channel. When the count runs out, it captures the converter result into that channel's data register and writes the channel's status register. It then moves on to the next enabled channel in ascending order, wrapping around at the top.

Each channel has a data-ready bit. A single active-low ready pin combines these bits in one of two ways: the pin goes low when any channel holds unread data, or only when every enabled channel does. Register reads appear as per-channel read-start and read-end strobes. A read-end clears the channel's ready bit. A result that completes during a read of its own channel is thrown away. A result that lands on top of unread data replaces it, and the pin is then held high for a fixed window so that the host can see the loss.

Top module: `conv_sequencer`

## Requirements
- R1: A mode write (`mode_wr` high for one cycle) clears every ready bit. From the next cycle on `rdy_n` is 1, and any conversion that completes in the cycle of the mode write is discarded.
- R2: A continuous mode write (`mode_cont`=1) starts on `mode_ch` if that channel is enabled in `en_mask`, and otherwise on the first enabled channel above it, wrapping from NCH-1 to 0. Each later conversion takes the next enabled channel by the same ascending wrap-around search.
- R3: A conversion lasts exactly the number of cycles programmed for its channel through `time_wr`/`time_ch`/`time_val`, and a value of 0 counts as 1. The first result is committed on the edge that ends cycle T after the mode write, and later results follow at cumulative sums. A mode write with `mode_cont`=0 stops all further conversions.
- R4: On commit, the channel's data register takes `adc_result`, its ready bit is set, and its status register becomes {overwrite flag, channel index}. The overwrite flag is bit CHW, and the index sits in bits CHW-1:0.
- R5: A pulse on `rd_end[c]` clears ready bit c, unless a result for channel c commits in that same cycle, in which case the set wins.
- R6: With `all_mode`=0 and no hold window active, `rdy_n` is 0 exactly when any ready bit is set.
- R7: With `all_mode`=1 and no hold window active, `rdy_n` is 0 only when `en_mask` is non-zero and every enabled channel's ready bit is set.
- R8: A commit on a channel that holds unread data replaces the data and sets the status overwrite flag. The ready bit drops and `rdy_n` is held high for exactly HOLD_CYC cycles (default 163). After that window the bit is set again and the pin follows R6/R7.
- R9: A result that completes for channel c while c is being read (`rd_start[c]` seen and `rd_end[c]` not yet seen) is dropped. Data, status and ready bit stay as they were until the read-end clears the bit.
- R10: With `en_mask` all zero, no conversion completes and no ready bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Mode register write strobe |
| mode_cont | input | 1 | 1 = continuous conversion, 0 = stop |
| mode_ch | input | CHW | Channel address of the mode write |
| en_mask | input | NCH | Per-channel enable |
| all_mode | input | 1 | Ready pin aggregation: 0 = any, 1 = all enabled |
| time_wr | input | 1 | Conversion-time write strobe |
| time_ch | input | CHW | Channel for the conversion-time write |
| time_val | input | TW | Conversion time in cycles |
| adc_result | input | DW | Converter result word |
| rd_start | input | NCH | Per-channel data read begins |
| rd_end | input | NCH | Per-channel data read ends |
| rd_sel | input | CHW | Channel shown on rd_data/rd_stat |
| rd_data | output | DW | Data register of rd_sel |
| rd_stat | output | CHW+1 | Status register of rd_sel |
| rdy_bits | output | NCH | Per-channel ready bits |
| rdy_n | output | 1 | Active-low ready pin |

## Verification
Every registered result becomes visible one edge after its cause. A commit shows up on the edge that ends the T-th cycle after the mode write or after the previous commit. A read-end clears its bit on its own edge. The overwrite window keeps `rdy_n` high for HOLD_CYC edges after the overwriting commit and releases it on the next one. The bench drives inputs on the falling edge and, from the programmed times, counts whole cycles to the edge where each change is due. It samples on the following falling edge; for the combinational read mux it waits one time unit after changing `rd_sel`. The channel order of the sweep is derived in the bench by its own wrap-around search, and the timing by summing the programmed times.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

  // first set bit of mask at or after 'from', searching upward with wrap
  function automatic int first_en(input logic [31:0] mask, input int n, input int from);
    int pick;
    pick = from % n;
    for (int k = 31; k >= 0; k--) begin
      if (k < n && mask[(from + k) % n]) pick = (from + k) % n;
    end
    return pick;
  endfunction

  // level of the active-low ready pin outside any hold window
  function automatic logic pin_level(input logic [31:0] bits, input logic [31:0] en,
                                     input logic all_mode);
    if (all_mode) return !((en != '0) && ((bits & en) == en));
    return !(bits != '0);
  endfunction

endpackage

// File: rtl/cseq_time_bank.sv
module cseq_time_bank #(
  parameter int NCH      = 4,
  parameter int TW       = 16,
  parameter int DEF_TIME = 16,
  localparam int CHW     = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr,
  input  logic [CHW-1:0] wr_ch,
  input  logic [TW-1:0]  wr_val,
  input  logic [CHW-1:0] a_ch,
  output logic [TW-1:0]  a_time,
  input  logic [CHW-1:0] b_ch,
  output logic [TW-1:0]  b_time
);
  logic [TW-1:0] t_q [NCH];

  for (genvar i = 0; i < NCH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         t_q[i] <= TW'(DEF_TIME);
      else if (wr && wr_ch == CHW'(i))    t_q[i] <= wr_val;
    end
  end

  // a stored zero behaves as a one-cycle conversion
  always_comb begin
    a_time = (t_q[a_ch] == '0) ? TW'(1) : t_q[a_ch];
    b_time = (t_q[b_ch] == '0) ? TW'(1) : t_q[b_ch];
  end
endmodule

// File: rtl/cseq_stepper.sv
module cseq_stepper
  import conv_seq_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int TW   = 16,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mode_wr,
  input  logic           mode_cont,
  input  logic [CHW-1:0] mode_ch,
  input  logic [NCH-1:0] en_mask,
  input  logic [TW-1:0]  t_start,
  input  logic [TW-1:0]  t_next,
  output logic [CHW-1:0] start_ch,
  output logic [CHW-1:0] next_ch,
  output logic           conv_done,
  output logic [CHW-1:0] done_ch
);
  logic           run_q;
  logic [CHW-1:0] cur_q;
  logic [TW-1:0]  tcnt_q;
  logic           any_en;

  assign any_en    = |en_mask;
  assign start_ch  = CHW'(first_en(32'(en_mask), NCH, int'(mode_ch)));
  assign next_ch   = CHW'(first_en(32'(en_mask), NCH, int'(cur_q) + 1));
  assign conv_done = run_q && any_en && (tcnt_q == TW'(1)) && !mode_wr;
  assign done_ch   = cur_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cur_q  <= '0;
      tcnt_q <= TW'(1);
    end else if (mode_wr) begin
      run_q  <= mode_cont;
      cur_q  <= start_ch;
      tcnt_q <= t_start;
    end else if (conv_done) begin
      cur_q  <= next_ch;
      tcnt_q <= t_next;
    end else if (run_q && any_en && tcnt_q > TW'(1)) begin
      tcnt_q <= tcnt_q - TW'(1);
    end
  end
endmodule

// File: rtl/cseq_ready.sv
module cseq_ready
  import conv_seq_pkg::*;
#(
  parameter int NCH      = 4,
  parameter int HOLD_CYC = 163,
  localparam int CHW     = $clog2(NCH),
  localparam int HW      = $clog2(HOLD_CYC + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mode_wr,
  input  logic           conv_done,
  input  logic [CHW-1:0] done_ch,
  input  logic [NCH-1:0] rd_start,
  input  logic [NCH-1:0] rd_end,
  input  logic [NCH-1:0] en_mask,
  input  logic           all_mode,
  output logic           commit,
  output logic           drop,
  output logic           ovwr,
  output logic [NCH-1:0] rdy_bits,
  output logic           rdy_n
);
  logic [NCH-1:0] rdy_q, pend_q, reading_q, busy_rd, done_vec, set_vec, ovr_vec;
  logic [HW-1:0]  hold_q;
  logic           restore;

  always_comb begin
    done_vec          = '0;
    done_vec[done_ch] = conv_done;
  end

  assign busy_rd = reading_q | rd_start;
  assign drop    = conv_done && busy_rd[done_ch];
  assign commit  = conv_done && !drop;
  assign ovwr    = commit && (rdy_q[done_ch] || pend_q[done_ch]);
  assign set_vec = (commit && !ovwr) ? done_vec : '0;
  assign ovr_vec = ovwr ? done_vec : '0;
  assign restore = (hold_q == HW'(1)) && !ovwr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reading_q <= '0;
    else        reading_q <= (reading_q | rd_start) & ~rd_end;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q  <= '0;
      pend_q <= '0;
      hold_q <= '0;
    end else if (mode_wr) begin
      rdy_q  <= '0;
      pend_q <= '0;
      hold_q <= '0;
    end else begin
      rdy_q  <= (rdy_q & ~rd_end & ~ovr_vec) | set_vec
              | (restore ? (pend_q & ~rd_end) : '0);
      pend_q <= restore ? '0 : ((pend_q & ~rd_end) | ovr_vec);
      if (ovwr)               hold_q <= HW'(HOLD_CYC);
      else if (hold_q != '0)  hold_q <= hold_q - HW'(1);
    end
  end

  assign rdy_bits = rdy_q;
  assign rdy_n    = (hold_q != '0) ? 1'b1 : pin_level(32'(rdy_q), 32'(en_mask), all_mode);
endmodule

// File: rtl/cseq_results.sv
module cseq_results #(
  parameter int NCH  = 4,
  parameter int DW   = 16,
  localparam int CHW = $clog2(NCH),
  localparam int SW  = CHW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            commit,
  input  logic [CHW-1:0]  done_ch,
  input  logic            ovr_flag,
  input  logic [DW-1:0]   result,
  input  logic [CHW-1:0]  rd_sel,
  output logic [DW-1:0]   rd_data,
  output logic [SW-1:0]   rd_stat,
  output logic [NCH*DW-1:0] data_flat
);
  logic [DW-1:0] data_q [NCH];
  logic [SW-1:0] stat_q [NCH];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_q[i] <= '0;
        stat_q[i] <= '0;
      end else if (commit && done_ch == CHW'(i)) begin
        data_q[i] <= result;
        stat_q[i] <= {ovr_flag, CHW'(i)};
      end
    end
    assign data_flat[i*DW +: DW] = data_q[i];
  end

  assign rd_data = data_q[rd_sel];
  assign rd_stat = stat_q[rd_sel];
endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer #(
  parameter int NCH      = 4,
  parameter int DW       = 16,
  parameter int TW       = 16,
  parameter int DEF_TIME = 16,
  parameter int HOLD_CYC = 163,
  localparam int CHW     = $clog2(NCH),
  localparam int SW      = CHW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mode_wr,
  input  logic           mode_cont,
  input  logic [CHW-1:0] mode_ch,
  input  logic [NCH-1:0] en_mask,
  input  logic           all_mode,
  input  logic           time_wr,
  input  logic [CHW-1:0] time_ch,
  input  logic [TW-1:0]  time_val,
  input  logic [DW-1:0]  adc_result,
  input  logic [NCH-1:0] rd_start,
  input  logic [NCH-1:0] rd_end,
  input  logic [CHW-1:0] rd_sel,
  output logic [DW-1:0]  rd_data,
  output logic [SW-1:0]  rd_stat,
  output logic [NCH-1:0] rdy_bits,
  output logic           rdy_n
);
  // internal events, named for the bound checker
  logic [CHW-1:0]    start_ch, next_ch, done_ch;
  logic [TW-1:0]     t_start, t_next;
  logic              conv_done, commit, drop, ovwr;
  logic [NCH*DW-1:0] data_flat;

  cseq_time_bank #(.NCH(NCH), .TW(TW), .DEF_TIME(DEF_TIME)) u_times (
    .clk(clk), .rst_n(rst_n), .wr(time_wr), .wr_ch(time_ch), .wr_val(time_val),
    .a_ch(start_ch), .a_time(t_start), .b_ch(next_ch), .b_time(t_next)
  );

  cseq_stepper #(.NCH(NCH), .TW(TW)) u_step (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_cont(mode_cont),
    .mode_ch(mode_ch), .en_mask(en_mask), .t_start(t_start), .t_next(t_next),
    .start_ch(start_ch), .next_ch(next_ch), .conv_done(conv_done), .done_ch(done_ch)
  );

  cseq_ready #(.NCH(NCH), .HOLD_CYC(HOLD_CYC)) u_ready (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .conv_done(conv_done),
    .done_ch(done_ch), .rd_start(rd_start), .rd_end(rd_end), .en_mask(en_mask),
    .all_mode(all_mode), .commit(commit), .drop(drop), .ovwr(ovwr),
    .rdy_bits(rdy_bits), .rdy_n(rdy_n)
  );

  cseq_results #(.NCH(NCH), .DW(DW)) u_res (
    .clk(clk), .rst_n(rst_n), .commit(commit), .done_ch(done_ch), .ovr_flag(ovwr),
    .result(adc_result), .rd_sel(rd_sel), .rd_data(rd_data), .rd_stat(rd_stat),
    .data_flat(data_flat)
  );
endmodule

// File: rtl/conv_sequencer_chk.sv
module conv_sequencer_chk #(
  parameter int NCH      = 4,
  parameter int DW       = 16,
  parameter int HOLD_CYC = 163,
  localparam int CHW     = $clog2(NCH),
  localparam int HW      = $clog2(HOLD_CYC + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_wr,
  input logic [NCH-1:0]    en_mask,
  input logic [NCH-1:0]    rd_end,
  input logic [NCH-1:0]    rdy_bits,
  input logic              rdy_n,
  input logic              conv_done,
  input logic [CHW-1:0]    done_ch,
  input logic              commit,
  input logic              drop,
  input logic              ovwr,
  input logic [NCH*DW-1:0] data_flat
);
  // independent window counter for the overwrite pulse
  logic [HW-1:0] win_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            win_q <= '0;
    else if (mode_wr)      win_q <= '0;
    else if (ovwr)         win_q <= HW'(HOLD_CYC);
    else if (win_q != '0)  win_q <= win_q - HW'(1);
  end

  a_r1_mode_clears: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> (rdy_bits == '0 && rdy_n));

  a_r4_commit_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !ovwr) |=> rdy_bits[$past(done_ch)]);

  a_r8_ovwr_drops: assert property (@(posedge clk) disable iff (!rst_n)
    ovwr |=> (!rdy_bits[$past(done_ch)] && rdy_n));

  a_r8_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
    (win_q != '0) |-> rdy_n);

  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (en_mask == '0) |-> !conv_done);

  for (genvar i = 0; i < NCH; i++) begin : g_c
    a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_end[i] && !(commit && done_ch == CHW'(i))) |=> !rdy_bits[i]);
    a_r9_drop_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (drop && done_ch == CHW'(i)) |=> $stable(data_flat[i*DW +: DW]));
  end
endmodule

bind conv_sequencer conv_sequencer_chk #(.NCH(NCH), .DW(DW), .HOLD_CYC(HOLD_CYC)) chk_i (
  .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .en_mask(en_mask), .rd_end(rd_end),
  .rdy_bits(rdy_bits), .rdy_n(rdy_n), .conv_done(conv_done), .done_ch(done_ch),
  .commit(commit), .drop(drop), .ovwr(ovwr), .data_flat(data_flat)
);

// File: tb/conv_sequencer_tb_top.sv
module conv_sequencer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int DW  = 16;
  localparam int TW  = 16;
  localparam int HOLD = 163;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_wr = 1'b0, mode_cont = 1'b0, all_mode = 1'b0, time_wr = 1'b0;
  logic [1:0]    mode_ch = '0, time_ch = '0, rd_sel = '0;
  logic [3:0]    en_mask = '0, rd_start = '0, rd_end = '0, rdy_bits;
  logic [TW-1:0] time_val = '0;
  logic [DW-1:0] adc_result = '0, rd_data;
  logic [2:0]    rd_stat;
  logic          rdy_n;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  int tconv [NCH];

  always #(CLK_PERIOD/2) clk = ~clk;

  conv_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_cont(mode_cont), .mode_ch(mode_ch),
    .en_mask(en_mask), .all_mode(all_mode), .time_wr(time_wr), .time_ch(time_ch),
    .time_val(time_val), .adc_result(adc_result), .rd_start(rd_start), .rd_end(rd_end),
    .rd_sel(rd_sel), .rd_data(rd_data), .rd_stat(rd_stat), .rdy_bits(rdy_bits), .rdy_n(rdy_n)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_mode(input logic cont, input int ch);
    mode_wr = 1'b1; mode_cont = cont; mode_ch = 2'(ch);
    step(1);
    mode_wr = 1'b0;
  endtask

  task automatic set_time(input int ch, input int val);
    time_wr = 1'b1; time_ch = 2'(ch); time_val = TW'(val);
    step(1);
    time_wr = 1'b0;
    tconv[ch] = val;
  endtask

  task automatic do_read(input int ch);
    rd_start = 4'(1 << ch); step(1); rd_start = '0;
    rd_end   = 4'(1 << ch); step(1); rd_end   = '0;
  endtask

  function automatic int bench_first(input int mask, input int from);
    for (int k = 0; k < NCH; k++)
      if (mask[(from + k) % NCH]) return (from + k) % NCH;
    return -1;
  endfunction

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // reset state
    check("R1 reset rdy_bits", 32'(rdy_bits), 0);
    check("R1 reset rdy_n", 32'(rdy_n), 1);
    check("R4 reset rd_data", 32'(rd_data), 0);

    // sweep: every non-empty mask, every start channel, any-mode pin
    for (int c = 0; c < NCH; c++) set_time(c, c + 3);
    for (int m = 1; m < 16; m++) begin
      for (int s = 0; s < NCH; s++) begin
        int ch, pc, waited;
        pc = $countones(4'(m));
        en_mask = 4'(m);
        ch = bench_first(m, s);
        adc_result = DW'(16'h1000 + m * 64 + s * 16);
        do_mode(1'b1, s);
        waited = 0;
        for (int j = 0; j < 2 * pc; j++) begin
          step(tconv[ch] - waited);
          rd_sel = 2'(ch); #1;
          check($sformatf("R2 R3 R4 bits m=%0d s=%0d j=%0d", m, s, j), 32'(rdy_bits), 32'(1 << ch));
          check("R6 any-mode pin low", 32'(rdy_n), 0);
          check("R4 data", 32'(rd_data), 32'(16'h1000 + m * 64 + s * 16 + j));
          check("R4 status", 32'(rd_stat), 32'(ch));
          adc_result = DW'(16'h1000 + m * 64 + s * 16 + j + 1);
          do_read(ch);
          check("R5 read clears", 32'(rdy_bits), 0);
          waited = 2;
          ch = bench_first(m, ch + 1);
        end
        do_mode(1'b0, 0);
        check("R1 mode write pin", 32'(rdy_n), 1);
      end
    end

    // stop mode: no further results
    en_mask = 4'b0001;
    do_mode(1'b1, 0);
    do_mode(1'b0, 0);
    step(12);
    check("R3 stopped", 32'(rdy_bits), 0);

    // all-mode aggregation
    set_time(0, 3); set_time(1, 4);
    en_mask = 4'b0011; all_mode = 1'b1;
    do_mode(1'b1, 0);
    step(3);
    check("R7 one of two ready bits", 32'(rdy_bits), 1);
    check("R7 pin high with one unread", 32'(rdy_n), 1);
    step(4);
    check("R7 both ready bits", 32'(rdy_bits), 3);
    check("R7 pin low when all unread", 32'(rdy_n), 0);
    all_mode = 1'b0; #1;
    check("R6 pin low in any mode", 32'(rdy_n), 0);
    do_mode(1'b0, 0);
    check("R1 clears after all-mode", 32'(rdy_bits), 0);
    check("R1 pin high", 32'(rdy_n), 1);

    // overwrite of unread data
    set_time(0, 200);
    en_mask = 4'b0001;
    adc_result = 16'hA111;
    do_mode(1'b1, 0);
    step(200);
    check("R4 first result ready", 32'(rdy_bits), 1);
    adc_result = 16'hA222;
    step(200);
    rd_sel = 2'd0; #1;
    check("R8 bit drops", 32'(rdy_bits), 0);
    check("R8 pin high", 32'(rdy_n), 1);
    check("R8 data replaced", 32'(rd_data), 32'h0000A222);
    check("R8 status overwrite flag", 32'(rd_stat), 32'b100);
    step(HOLD - 1);
    check("R8 pin still high at window end", 32'(rdy_n), 1);
    step(1);
    check("R8 pin released", 32'(rdy_n), 0);
    check("R8 bit restored", 32'(rdy_bits), 1);
    do_mode(1'b0, 0);

    // read collides with completion
    set_time(0, 10);
    adc_result = 16'hB111;
    do_mode(1'b1, 0);
    step(10);
    check("R4 first result before collision", 32'(rdy_bits), 1);
    adc_result = 16'hB222;
    step(8);
    rd_start = 4'b0001; step(1); rd_start = '0;
    step(1);
    rd_sel = 2'd0; #1;
    check("R9 bit kept during read", 32'(rdy_bits), 1);
    check("R9 no overwrite pulse", 32'(rdy_n), 0);
    check("R9 data unchanged", 32'(rd_data), 32'h0000B111);
    rd_end = 4'b0001; step(1); rd_end = '0;
    check("R9 read-end clears", 32'(rdy_bits), 0);
    check("R9 status untouched", 32'(rd_stat), 0);
    do_mode(1'b0, 0);

    // no enabled channel
    en_mask = '0;
    do_mode(1'b1, 2);
    step(40);
    check("R10 idle bits", 32'(rdy_bits), 0);
    check("R10 idle pin", 32'(rdy_n), 1);
    do_mode(1'b0, 0);

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule